// File: doc/BRIEF.md
# Load/Store Alignment and Lane Unit

This block sits between the execute stage of a 32-bit core and its data bus. Each cycle it may take one memory request: an effective byte address, an access width (byte, halfword or word), a sign/zero flag, a load/store direction and store data. In the same cycle it decides whether the access is naturally aligned. A legal access goes out as a bus request with a word-aligned address, per-byte write strobes and store data copied onto every lane. A misaligned access raises a precise trap instead, with the cause code and the faulting address. Misaligned accesses are never split or emulated.

For a legal load, the block keeps the width, extension mode and byte offset of the request in a small pending register. When the bus later returns the word (`bus_rvalid_i`), the block picks the addressed lanes, sign- or zero-extends them and asserts the register-file write enable for that one cycle. A misaligned load creates no pending entry. Its destination register is never written. A misaligned store raises no strobe, so memory is left unchanged.

Width encoding on `req_size_i` is 0 for byte, 1 for halfword and 2 for word. The value 3 is reserved and treated as word. Only one load may be outstanding at a time.

Top module: `lsu_lane_unit`

## Requirements
- R1: A byte access is aligned at every offset. A halfword is aligned only when address bits [1:0] are 0 or 2. A word is aligned only when address bits [1:0] are 0. `exc_valid_o` is high exactly when `req_valid_i` is high and the access is misaligned.
- R2: On a trap, `exc_cause_o` is 4 for a load and 6 for a store, and `exc_tval_o` equals the full request address.
- R3: On a trap, `bus_valid_o` is low and `bus_strb_o` is zero, so the addressed memory word keeps its previous value.
- R4: A misaligned load never asserts `rd_we_o`, even if `bus_rvalid_i` is pulsed afterwards. In general, `bus_rvalid_i` with no outstanding legal load has no effect.
- R5: For a legal access, `bus_valid_o` is high, `bus_addr_o` is the request address with bits [1:0] cleared, and `bus_we_o` is high for stores and low for loads.
- R6: Strobes for a legal store: a byte sets only bit `addr[1:0]`, a halfword sets bits `addr[1:0]` and `addr[1:0]+1`, and a word sets all four. Loads drive no strobes.
- R7: Store data is replicated. A byte value goes into all four lanes, a halfword into both halves, and a word is passed through unchanged.
- R8: Load lanes are little-endian. The result takes the bytes starting at `addr[1:0]` of the returned word, so a word load returns the word unchanged.
- R9: Byte and halfword loads sign-extend from bit 7 or 15 when `req_unsigned_i` is 0 and zero-extend when it is 1.
- R10: For a legal load, `rd_we_o` is high exactly in the first cycle in which `bus_rvalid_i` is high after the request. It is low before that cycle, and `rd_data_o` is zero whenever `rd_we_o` is low.
- R11: While and after reset, with no request, `bus_valid_o`, `exc_valid_o` and `rd_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Effective byte address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_unsigned_i | input | 1 | Zero-extend a narrow load |
| req_store_i | input | 1 | 1 store, 0 load |
| req_wdata_i | input | 32 | Store data, right-aligned |
| bus_valid_o | output | 1 | Bus transfer issued |
| bus_addr_o | output | 32 | Word-aligned bus address |
| bus_we_o | output | 1 | Bus write |
| bus_strb_o | output | 4 | Byte-lane write strobes |
| bus_wdata_o | output | 32 | Lane-replicated write data |
| bus_rvalid_i | input | 1 | Read data returned |
| bus_rdata_i | input | 32 | Returned word |
| exc_valid_o | output | 1 | Misalignment trap |
| exc_cause_o | output | 5 | Trap cause code |
| exc_tval_o | output | 32 | Faulting address |
| rd_we_o | output | 1 | Destination register write |
| rd_data_o | output | 32 | Extended load result |

## Verification
The pending-load register is the only state in the block. If it holds a wrong width, offset or sign flag, the error shows in `rd_data_o` in the single cycle that `bus_rvalid_i` returns. If it holds a stale valid bit, `rd_we_o` rises on a response that belongs to no load, and this shows at the first `bus_rvalid_i` pulse after a trap or after reset. The request path is purely combinational, so a fault in alignment, strobes or replication is visible at the ports in the same cycle the request is presented.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  localparam int CAUSE_LOAD_MISALIGN  = 4;
  localparam int CAUSE_STORE_MISALIGN = 6;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_lane_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  size_e            size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             misaligned_o
);
  logic [OFF_W-1:0] low_mask;

  // natural alignment: low log2(size) offset bits must be zero
  always_comb begin
    unique case (size_i)
      SZ_BYTE: low_mask = '0;
      SZ_HALF: low_mask = OFF_W'(1);
      default: low_mask = '1;
    endcase
  end

  assign misaligned_o = |(off_i & low_mask);
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              en_i,
  input  size_e             size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  strb_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [LANES-1:0] base;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: base = LANES'(1);
      SZ_HALF: base = LANES'(3);
      default: base = '1;
    endcase
    strb_o = en_i ? (base << off_i) : '0;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[8*i +: 8] = wdata_i[7:0];
        SZ_HALF: wdata_o[8*i +: 8] = wdata_i[8*(i%2) +: 8];
        default: wdata_o[8*i +: 8] = wdata_i[8*i +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_format.sv
module lsu_load_format
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  size_e             size_i,
  input  logic              unsigned_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] shifted;
  logic              sbit;

  assign shifted = rdata_i >> {off_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        sbit     = shifted[7] & ~unsigned_i;
        result_o = {{(DATA_W-8){sbit}}, shifted[7:0]};
      end
      SZ_HALF: begin
        sbit     = shifted[15] & ~unsigned_i;
        result_o = {{(DATA_W-16){sbit}}, shifted[15:0]};
      end
      default: begin
        sbit     = 1'b0;
        result_o = shifted;
      end
    endcase
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 5,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic               req_unsigned_i,
  input  logic               req_store_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               bus_valid_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  output logic               bus_we_o,
  output logic [LANES-1:0]   bus_strb_o,
  output logic [DATA_W-1:0]  bus_wdata_o,
  input  logic               bus_rvalid_i,
  input  logic [DATA_W-1:0]  bus_rdata_i,
  output logic               exc_valid_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic [ADDR_W-1:0]  exc_tval_o,
  output logic               rd_we_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  size_e            size;
  logic [OFF_W-1:0] off;
  logic             misaligned;
  logic             issue;
  logic [DATA_W-1:0] fmt_data;

  // pending load context
  logic             pend_q;
  size_e            pend_size_q;
  logic             pend_uns_q;
  logic [OFF_W-1:0] pend_off_q;

  assign size = size_e'(req_size_i);
  assign off  = req_addr_i[OFF_W-1:0];

  lsu_align_check #(.OFF_W(OFF_W)) u_align (
    .size_i       (size),
    .off_i        (off),
    .misaligned_o (misaligned)
  );

  assign issue       = req_valid_i & ~misaligned;
  assign exc_valid_o = req_valid_i & misaligned;
  assign exc_cause_o = !exc_valid_o ? '0 :
                       req_store_i  ? CAUSE_W'(CAUSE_STORE_MISALIGN) :
                                      CAUSE_W'(CAUSE_LOAD_MISALIGN);
  assign exc_tval_o  = exc_valid_o ? req_addr_i : '0;

  assign bus_valid_o = issue;
  assign bus_we_o    = issue & req_store_i;
  assign bus_addr_o  = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  lsu_store_lanes #(.DATA_W(DATA_W)) u_lanes (
    .en_i    (bus_we_o),
    .size_i  (size),
    .off_i   (off),
    .wdata_i (req_wdata_i),
    .strb_o  (bus_strb_o),
    .wdata_o (bus_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_size_q <= SZ_BYTE;
      pend_uns_q  <= 1'b0;
      pend_off_q  <= '0;
    end else if (issue && !req_store_i) begin
      pend_q      <= 1'b1;
      pend_size_q <= size;
      pend_uns_q  <= req_unsigned_i;
      pend_off_q  <= off;
    end else if (bus_rvalid_i) begin
      pend_q      <= 1'b0;
    end
  end

  lsu_load_format #(.DATA_W(DATA_W)) u_fmt (
    .size_i     (pend_size_q),
    .unsigned_i (pend_uns_q),
    .off_i      (pend_off_q),
    .rdata_i    (bus_rdata_i),
    .result_o   (fmt_data)
  );

  assign rd_we_o   = pend_q & bus_rvalid_i;
  assign rd_data_o = rd_we_o ? fmt_data : '0;

  // R3: a trap issues no transfer and no strobe
  a_r3_trap_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> (!bus_valid_o && bus_strb_o == '0));

  // R5: bus address always word aligned
  a_r5_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (bus_addr_o[OFF_W-1:0] == '0));

  // R1: odd halfword offset must trap
  a_r1_half_odd_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 2'd1 && req_addr_i[0]) |-> exc_valid_o);

  // R6: byte store drives exactly one lane
  a_r6_byte_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && req_size_i == 2'd0) |-> ($countones(bus_strb_o) == 1));

  // R10: response after an issued load writes the register
  a_r10_resp_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_we_o) |=> (rd_we_o == bus_rvalid_i));

  // R4: trapped load with nothing outstanding never writes the register
  a_r4_trap_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o && !req_store_i && !pend_q) |=> !rd_we_o);

  // R9: unsigned halfword result has zero upper half
  a_r9_uhalf_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_we_o && pend_size_q == SZ_HALF && pend_uns_q) |-> (rd_data_o[DATA_W-1:16] == '0));
endmodule

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_unsigned_i = 1'b0;
  logic        req_store_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        bus_valid_o;
  logic [31:0] bus_addr_o;
  logic        bus_we_o;
  logic [3:0]  bus_strb_o;
  logic [31:0] bus_wdata_o;
  logic        bus_rvalid_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic        exc_valid_o;
  logic [4:0]  exc_cause_o;
  logic [31:0] exc_tval_o;
  logic        rd_we_o;
  logic [31:0] rd_data_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] mem [0:7];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lsu_lane_unit u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_size_i, .req_unsigned_i,
    .req_store_i, .req_wdata_i, .bus_valid_o, .bus_addr_o, .bus_we_o,
    .bus_strb_o, .bus_wdata_o, .bus_rvalid_i, .bus_rdata_i, .exc_valid_o,
    .exc_cause_o, .exc_tval_o, .rd_we_o, .rd_data_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08x expected=%08x", tag, act, exp);
    end
  endtask

  function automatic bit f_mis(input logic [1:0] sz, input logic [1:0] off);
    if (sz == 2'd0) return 1'b0;
    if (sz == 2'd1) return off[0];
    return off != 2'd0;
  endfunction

  function automatic logic [3:0] f_strb(input logic [1:0] sz, input logic [1:0] off);
    if (sz == 2'd0) return 4'b0001 << off;
    if (sz == 2'd1) return 4'b0011 << off;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] f_wdata(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'd0) return {4{d[7:0]}};
    if (sz == 2'd1) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] f_load(input logic [1:0] sz, input bit uns,
                                         input logic [1:0] off, input logic [31:0] w);
    logic [31:0] s;
    s = w >> (8 * off);
    if (sz == 2'd0) return uns ? {24'h0, s[7:0]} : {{24{s[7]}}, s[7:0]};
    if (sz == 2'd1) return uns ? {16'h0, s[15:0]} : {{16{s[15]}}, s[15:0]};
    return s;
  endfunction

  task automatic access(input logic [1:0] sz, input bit uns, input bit st,
                        input logic [31:0] addr, input logic [31:0] wd);
    bit mis;
    int idx;
    logic [31:0] w;
    mis = f_mis(sz, addr[1:0]);
    idx = int'(addr[4:2]);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = addr; req_size_i = sz;
    req_unsigned_i = uns; req_store_i = st; req_wdata_i = wd;
    #1;
    chk(exc_valid_o == mis, "R1 exc_valid", 32'(exc_valid_o), 32'(mis));
    if (mis) begin
      chk(exc_cause_o == (st ? 5'd6 : 5'd4), "R2 cause", 32'(exc_cause_o), st ? 32'd6 : 32'd4);
      chk(exc_tval_o == addr, "R2 tval", exc_tval_o, addr);
      chk(!bus_valid_o && bus_strb_o == 4'h0, "R3 bus quiet on trap",
          {bus_valid_o, 27'h0, bus_strb_o}, 32'h0);
    end else begin
      chk(bus_valid_o && bus_addr_o == {addr[31:2], 2'b00} && bus_we_o == st,
          "R5 bus addr/we", bus_addr_o, {addr[31:2], 2'b00});
      chk(bus_strb_o == (st ? f_strb(sz, addr[1:0]) : 4'h0), "R6 strobes",
          32'(bus_strb_o), st ? 32'(f_strb(sz, addr[1:0])) : 32'h0);
      if (st)
        chk(bus_wdata_o == f_wdata(sz, wd), "R7 wdata", bus_wdata_o, f_wdata(sz, wd));
    end
    // memory model, driven from the bus
    if (bus_valid_o || bus_strb_o != 4'h0) begin
      w = mem[idx];
      for (int b = 0; b < 4; b++)
        if (bus_strb_o[b]) w[8*b +: 8] = bus_wdata_o[8*b +: 8];
      mem[idx] = w;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (!st) begin
      #1;
      chk(rd_we_o == 1'b0, "R10 no early write", 32'(rd_we_o), 32'h0);
      bus_rvalid_i = 1'b1; bus_rdata_i = mem[idx];
      #1;
      if (mis) begin
        chk(rd_we_o == 1'b0, "R4 trapped load no write", 32'(rd_we_o), 32'h0);
      end else begin
        chk(rd_we_o == 1'b1, "R10 write on response", 32'(rd_we_o), 32'h1);
        chk(rd_data_o == f_load(sz, uns, addr[1:0], mem[idx]),
            (sz == 2'd2) ? "R8 lane select" : "R9 extension",
            rd_data_o, f_load(sz, uns, addr[1:0], mem[idx]));
      end
      @(posedge clk_i);
      @(negedge clk_i);
      bus_rvalid_i = 1'b0;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] a;
    logic [1:0]  sz;
    void'($urandom(32'd2021));
    for (int i = 0; i < 8; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk_i);
    chk(!bus_valid_o && !exc_valid_o && !rd_we_o, "R11 reset idle",
        {bus_valid_o, exc_valid_o, rd_we_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    bus_rvalid_i = 1'b1; bus_rdata_i = 32'hdeadbeef;
    #1;
    chk(!rd_we_o && rd_data_o == 32'h0, "R11 R4 stray response", rd_data_o, 32'h0);
    @(negedge clk_i);
    bus_rvalid_i = 1'b0;

    // directed: halfword loads on a known word
    mem[0] = 32'h1234cdef;
    for (int u = 0; u < 2; u++)
      for (int o = 0; o < 4; o++) access(2'd1, u[0], 1'b0, 32'(o), 32'h0);
    mem[0] = 32'hffffffff;
    for (int o = 0; o < 4; o++) access(2'd2, 1'b0, 1'b0, 32'(o), 32'h0);

    // directed: halfword stores
    mem[1] = 32'hffffffff;
    access(2'd1, 1'b0, 1'b1, 32'd5, 32'h0);
    access(2'd1, 1'b0, 1'b1, 32'd7, 32'h0);
    chk(mem[1] == 32'hffffffff, "R3 word unchanged", mem[1], 32'hffffffff);
    access(2'd1, 1'b0, 1'b1, 32'd4, 32'h0);
    chk(mem[1] == 32'hffff0000, "R6 low half cleared", mem[1], 32'hffff0000);
    access(2'd1, 1'b0, 1'b1, 32'd6, 32'h0);
    chk(mem[1] == 32'h00000000, "R6 high half cleared", mem[1], 32'h0);

    // directed: word stores
    mem[2] = 32'hffffffff;
    for (int o = 1; o < 4; o++) access(2'd2, 1'b0, 1'b1, 32'(8 + o), 32'h0);
    chk(mem[2] == 32'hffffffff, "R3 word store trap", mem[2], 32'hffffffff);
    access(2'd2, 1'b0, 1'b1, 32'd8, 32'h0);
    chk(mem[2] == 32'h0, "R5 aligned word store", mem[2], 32'h0);

    // directed: bytes
    mem[3] = 32'h0;
    access(2'd0, 1'b0, 1'b1, 32'd13, 32'h000000a5);
    chk(mem[3] == 32'h0000a500, "R7 byte lane 1", mem[3], 32'h0000a500);
    access(2'd0, 1'b0, 1'b0, 32'd13, 32'h0);
    access(2'd0, 1'b1, 1'b0, 32'd13, 32'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      a  = $urandom() & 32'h1f;
      sz = 2'($urandom() % 3);
      access(sz, 1'($urandom()), 1'($urandom()), a | ($urandom() & 32'hffff_ff00), $urandom());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule